// File: doc/BRIEF.md
# Two-Bank SDRAM Command Tracker

This block watches the command pins of a two-bank synchronous DRAM on every clock edge. It turns the chip-select, row-strobe, column-strobe and write-enable levels into a command. It keeps each bank's state: idle or active, plus the row that was opened last. It also enforces the recovery windows that follow a mode-register load, a precharge and an auto-refresh. Each sampled command comes back one cycle later on registered outputs. These outputs carry the decoded command, the bank, the row or column field, the A10 flag, and a violation code. The code says why an illegal command was refused.

The pins are sampled on every edge and cannot be held off. The block has no valid/ready handshake and no back-pressure: every edge carries exactly one command, and deselect or no-operation fills the idle cycles. A refused command never changes the tracked state, so the tracker reflects what a correct device would have done.

The recovery lengths are parameters, counted in clock cycles. Defaults are T_MCD=2, T_RP=3, T_RC=7 and BURST_LEN=4. The burst length sets when an auto-precharge completes.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Commands decode from (cs_n, ras_n, cas_n, we_n) onto cmd_o codes as follows:
  - cs_n=1 is deselect (0).
  - 0111 is no-operation (1).
  - 0000 is mode-register load (2).
  - 0011 is activate (3).
  - 0010 is precharge (4).
  - 0101 is read (5).
  - 0100 is write (6).
  - 0001 with cke=1 is auto-refresh (7).
  - Any other pattern, including 0001 with cke=0, is other (8).
- R2: An accepted activate opens the bank given by addr[11] and records row addr[10:0]. cmd_bank_o shows addr[11] and cmd_rowcol_o shows addr[10:0]. open_rows_o holds bank 0's row in bits [10:0] and bank 1's row in bits [21:11]; a row stays there after its bank closes.
- R3: A read or write reports bank addr[11], column {0, addr[9:0]} on cmd_rowcol_o and addr[10] on cmd_ap_o. With addr[10]=0 the bank stays active.
- R4: An accepted read or write with addr[10]=1 keeps its bank active for BURST_LEN edges and then closes it. The bank accepts its next command no earlier than BURST_LEN+T_RP edges after the read or write.
- R5: A precharge with addr[10]=1 closes both banks. With addr[10]=0 it closes only bank addr[11]. cmd_ap_o shows addr[10]. Closing an idle bank is legal.
- R6: A mode-register load or auto-refresh while any bank is active is refused with code 1.
- R7: After an accepted mode-register load, the next non-idle command is accepted no earlier than T_MCD edges later; after an auto-refresh, no earlier than T_RC edges later. After a bank closes, commands touching that bank are accepted no earlier than T_RP edges later. A command inside such a window gets code 3, and this check takes priority over codes 1, 2 and 4.
- R8: A read or write to an idle bank is refused with code 2.
- R9: An activate to a bank that is already active is refused with code 4.
- R10: An accepted mode-register load copies addr[11:0] into mode_reg_o.
- R11: Deselect, no-operation and other never raise a violation, even inside a window, and change no state.
- R12: A refused command changes neither the bank states, the open rows, the mode register nor any window.
- R13: All outputs are registered: a command sampled at one edge appears after that edge. After reset, every output is zero and viol_o is low with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable level |
| addr | input | 12 | Address pins |
| cmd_o | output | 4 | Decoded command code (R1) |
| cmd_bank_o | output | 1 | Bank of the last command |
| cmd_rowcol_o | output | 11 | Row or column field |
| cmd_ap_o | output | 1 | addr[10] on read, write and precharge |
| viol_o | output | 1 | Last command was refused |
| viol_code_o | output | 3 | 0 none, 1 not idle, 2 bank idle, 3 window, 4 already active |
| bank_active_o | output | 2 | Per-bank active flags |
| open_rows_o | output | 22 | Last opened row per bank |
| mode_reg_o | output | 12 | Mode register copy |

## Verification
A wrong bank flag shows at the ports one edge after the command that corrupted it. It surfaces on bank_active_o, and the next read, write or activate to that bank carries a wrong violation code. A window counter that runs short or long shows as code 3 appearing or missing on a command issued near the end of the window. An auto-precharge off by one cycle shows as bank_active_o dropping on the wrong edge. The bench compares every output on every cycle against its own model, so each such fault is reported within a few cycles of the first stimulus that touches it.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_ACT   = 4'd3,
    CMD_PRE   = 4'd4,
    CMD_RD    = 4'd5,
    CMD_WR    = 4'd6,
    CMD_REF   = 4'd7,
    CMD_OTHER = 4'd8
  } sdt_cmd_e;

  typedef enum logic [2:0] {
    VIO_NONE       = 3'd0,
    VIO_NOT_IDLE   = 3'd1,
    VIO_NOT_ACTIVE = 3'd2,
    VIO_WINDOW     = 3'd3,
    VIO_ALREADY    = 3'd4
  } sdt_vio_e;

  localparam int NBANK = 2;
endpackage

// File: rtl/sdt_decode.sv
module sdt_decode
  import sdt_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  input  logic     cke,
  output sdt_cmd_e cmd
);
  always_comb begin
    cmd = CMD_OTHER;
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b000:  cmd = CMD_MRS;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = CMD_PRE;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b001:  cmd = cke ? CMD_REF : CMD_OTHER;
        default: cmd = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/sdt_timer.sv
module sdt_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);

  AST_WIN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt == $past(cnt) - W'(1))); // R7
  AST_NO_RELOAD_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt == '0)); // R7
endmodule

// File: rtl/sdt_bank.sv
module sdt_bank #(
  parameter int ROW_W     = 11,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic             ap_go,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic [ROW_W-1:0] row,
  output logic             busy
);
  localparam int RP_W = $clog2(T_RP + 1);
  localparam int AP_W = $clog2(BURST_LEN + 1);

  logic [RP_W-1:0] rp_cnt;
  logic [AP_W-1:0] ap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      row    <= '0;
      rp_cnt <= '0;
      ap_cnt <= '0;
    end else if (pre_go) begin
      active <= 1'b0;
      rp_cnt <= RP_W'(T_RP - 1);
    end else if (act_go) begin
      active <= 1'b1;
      row    <= row_in;
    end else if (ap_go) begin
      ap_cnt <= AP_W'(BURST_LEN);
    end else if (ap_cnt != '0) begin
      ap_cnt <= ap_cnt - AP_W'(1);
      if (ap_cnt == AP_W'(1)) begin
        active <= 1'b0;
        rp_cnt <= RP_W'(T_RP - 1);
      end
    end else if (rp_cnt != '0) begin
      rp_cnt <= rp_cnt - RP_W'(1);
    end
  end

  assign busy = (rp_cnt != '0) || (ap_cnt != '0);

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> (active && row == $past(row_in))); // R2
  AST_GO_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go || pre_go || ap_go) |-> !busy); // R7
  AST_AP_HOLDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_cnt != '0) |-> active); // R4
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdt_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int T_MCD     = 2,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int BURST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic                    cke,
  input  logic [ADDR_W-1:0]       addr,
  output logic [3:0]              cmd_o,
  output logic                    cmd_bank_o,
  output logic [ADDR_W-2:0]       cmd_rowcol_o,
  output logic                    cmd_ap_o,
  output logic                    viol_o,
  output logic [2:0]              viol_code_o,
  output logic [1:0]              bank_active_o,
  output logic [2*(ADDR_W-1)-1:0] open_rows_o,
  output logic [ADDR_W-1:0]       mode_reg_o
);
  localparam int ROW_W = ADDR_W - 1;
  localparam int COL_W = ADDR_W - 2;
  localparam int G_MAX = (T_MCD > T_RC) ? T_MCD : T_RC;
  localparam int G_W   = $clog2(G_MAX + 1);

  sdt_cmd_e  cmd;
  sdt_vio_e  code;
  logic      bsel, a10, ok, g_busy;
  logic [NBANK-1:0] act_go, pre_go, ap_go, b_active, b_busy;
  logic [ROW_W-1:0] b_row [NBANK];

  assign bsel = addr[ADDR_W-1];
  assign a10  = addr[ADDR_W-2];

  sdt_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .cmd(cmd)
  );

  always_comb begin
    code = VIO_NONE;
    unique case (cmd)
      CMD_MRS, CMD_REF: begin
        if (g_busy || (|b_busy)) code = VIO_WINDOW;
        else if (|b_active)      code = VIO_NOT_IDLE;
      end
      CMD_ACT: begin
        if (g_busy || b_busy[bsel]) code = VIO_WINDOW;
        else if (b_active[bsel])    code = VIO_ALREADY;
      end
      CMD_RD, CMD_WR: begin
        if (g_busy || b_busy[bsel]) code = VIO_WINDOW;
        else if (!b_active[bsel])   code = VIO_NOT_ACTIVE;
      end
      CMD_PRE: begin
        if (g_busy || (a10 ? (|b_busy) : b_busy[bsel])) code = VIO_WINDOW;
      end
      default: code = VIO_NONE;
    endcase
  end

  assign ok = (code == VIO_NONE);

  sdt_timer #(.W(G_W)) u_gwin (
    .clk(clk), .rst_n(rst_n),
    .load(ok && (cmd == CMD_MRS || cmd == CMD_REF)),
    .load_val((cmd == CMD_MRS) ? G_W'(T_MCD - 1) : G_W'(T_RC - 1)),
    .busy(g_busy)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit       = (int'(bsel) == b);
    assign act_go[b] = ok && cmd == CMD_ACT && hit;
    assign pre_go[b] = ok && cmd == CMD_PRE && (a10 || hit);
    assign ap_go[b]  = ok && (cmd == CMD_RD || cmd == CMD_WR) && a10 && hit;

    sdt_bank #(.ROW_W(ROW_W), .T_RP(T_RP), .BURST_LEN(BURST_LEN)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_go(act_go[b]), .pre_go(pre_go[b]), .ap_go(ap_go[b]),
      .row_in(addr[ROW_W-1:0]),
      .active(b_active[b]), .row(b_row[b]), .busy(b_busy[b])
    );
    assign open_rows_o[b*ROW_W +: ROW_W] = b_row[b];
  end

  assign bank_active_o = b_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o        <= 4'd0;
      cmd_bank_o   <= 1'b0;
      cmd_rowcol_o <= '0;
      cmd_ap_o     <= 1'b0;
      viol_o       <= 1'b0;
      viol_code_o  <= 3'd0;
      mode_reg_o   <= '0;
    end else begin
      cmd_o        <= cmd;
      viol_o       <= !ok;
      viol_code_o  <= code;
      cmd_bank_o   <= 1'b0;
      cmd_rowcol_o <= '0;
      cmd_ap_o     <= 1'b0;
      unique case (cmd)
        CMD_ACT: begin
          cmd_bank_o   <= bsel;
          cmd_rowcol_o <= addr[ROW_W-1:0];
        end
        CMD_RD, CMD_WR: begin
          cmd_bank_o   <= bsel;
          cmd_rowcol_o <= ROW_W'(addr[COL_W-1:0]);
          cmd_ap_o     <= a10;
        end
        CMD_PRE: begin
          cmd_bank_o   <= bsel;
          cmd_ap_o     <= a10;
        end
        default: ;
      endcase
      if (ok && cmd == CMD_MRS) mode_reg_o <= addr;
    end
  end

  AST_RW_BANK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == CMD_RD || cmd_o == CMD_WR) && !viol_o) |-> bank_active_o[cmd_bank_o]); // R3
  AST_ACT_LEAVES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT && !viol_o) |-> bank_active_o[cmd_bank_o]); // R2
  AST_IDLE_AFTER_MRS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == CMD_MRS || cmd_o == CMD_REF) && !viol_o) |-> (bank_active_o == 2'b00)); // R6
  AST_REFUSED_MRS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o && cmd_o == CMD_MRS) |-> $stable(mode_reg_o)); // R12
  AST_QUIET_NO_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_DESEL || cmd_o == CMD_NOP || cmd_o == CMD_OTHER) |-> !viol_o); // R11
endmodule

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;
  localparam int TMCD = 2, TRP = 3, TRC = 7, BL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [11:0] addr = '0;
  logic [3:0]  cmd_o;
  logic        cmd_bank_o, cmd_ap_o, viol_o;
  logic [10:0] cmd_rowcol_o;
  logic [2:0]  viol_code_o;
  logic [1:0]  bank_active_o;
  logic [21:0] open_rows_o;
  logic [11:0] mode_reg_o;

  sdram_cmd_tracker #(.ADDR_W(12), .T_MCD(TMCD), .T_RP(TRP), .T_RC(TRC), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .addr(addr), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
    .cmd_rowcol_o(cmd_rowcol_o), .cmd_ap_o(cmd_ap_o), .viol_o(viol_o),
    .viol_code_o(viol_code_o), .bank_active_o(bank_active_o),
    .open_rows_o(open_rows_o), .mode_reg_o(mode_reg_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // Reference model state
  int m_act[2], m_row[2], m_rp[2], m_ap[2], m_g, m_mode;
  int e_cmd, e_bank, e_rc, e_ap, e_code;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit busy_b(int b);
    return (m_rp[b] != 0) || (m_ap[b] != 0);
  endfunction

  function automatic int cmd_code(logic c, logic r, logic ca, logic w, logic k);
    if (c) return 0;
    case ({r, ca, w})
      3'b111: return 1;
      3'b000: return 2;
      3'b011: return 3;
      3'b010: return 4;
      3'b101: return 5;
      3'b100: return 6;
      3'b001: return k ? 7 : 8;
      default: return 8;
    endcase
  endfunction

  function automatic string tag_of(int c, int code, logic a10);
    if (code == 1) return "R6";
    if (code == 2) return "R8";
    if (code == 3) return "R7";
    if (code == 4) return "R9";
    case (c)
      2: return "R10";
      3: return "R2";
      4: return "R5";
      5, 6: return a10 ? "R4" : "R3";
      7: return "R6";
      default: return "R11";
    endcase
  endfunction

  // Model one edge: compute expected outputs and next state
  task automatic model_step(logic [11:0] a);
    int b; logic a10; bit ok; bit anyb; bit anya;
    e_cmd = cmd_code(cs_n, ras_n, cas_n, we_n, cke);
    b = a[11]; a10 = a[10];
    anyb = busy_b(0) || busy_b(1);
    anya = (m_act[0] != 0) || (m_act[1] != 0);
    e_code = 0;
    case (e_cmd)
      2, 7: if (m_g != 0 || anyb) e_code = 3; else if (anya) e_code = 1;
      3: if (m_g != 0 || busy_b(b)) e_code = 3; else if (m_act[b] != 0) e_code = 4;
      5, 6: if (m_g != 0 || busy_b(b)) e_code = 3; else if (m_act[b] == 0) e_code = 2;
      4: if (m_g != 0 || (a10 ? anyb : busy_b(b))) e_code = 3;
      default: e_code = 0;
    endcase
    ok = (e_code == 0);
    e_bank = 0; e_rc = 0; e_ap = 0;
    if (e_cmd == 3) begin e_bank = b; e_rc = a[10:0]; end
    if (e_cmd == 5 || e_cmd == 6) begin e_bank = b; e_rc = a[9:0]; e_ap = a10; end
    if (e_cmd == 4) begin e_bank = b; e_ap = a10; end
    // time passes
    for (int i = 0; i < 2; i++) begin
      if (m_ap[i] != 0) begin
        if (m_ap[i] == 1) begin m_act[i] = 0; m_rp[i] = TRP - 1; end
        m_ap[i]--;
      end else if (m_rp[i] != 0) m_rp[i]--;
    end
    if (m_g != 0) m_g--;
    if (ok) begin
      case (e_cmd)
        2: begin m_mode = a; m_g = TMCD - 1; end
        7: m_g = TRC - 1;
        3: begin m_act[b] = 1; m_row[b] = a[10:0]; end
        4: for (int i = 0; i < 2; i++)
             if (a10 || i == b) begin m_act[i] = 0; m_rp[i] = TRP - 1; end
        5, 6: if (a10) m_ap[b] = BL;
        default: ;
      endcase
    end
  endtask

  task automatic drive(int c, logic [11:0] a, logic k);
    cke = k; addr = a;
    case (c)
      0: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      1: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      2: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
      3: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      4: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      5: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      6: {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      7: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0110;
    endcase
  endtask

  task automatic step(int c, logic [11:0] a, logic k = 1'b1);
    string t, ts;
    @(negedge clk);
    drive(c, a, k);
    model_step(a);
    t = tag_of(e_cmd, e_code, a[10]);
    ts = (e_code != 0) ? "R12" : t;
    @(posedge clk); #2;
    chk("R1", "cmd", cmd_o, e_cmd);
    chk(t, "code", viol_code_o, e_code);
    chk(t, "viol", viol_o, e_code != 0);
    chk(t, "bank", cmd_bank_o, e_bank);
    chk(t, "rowcol", cmd_rowcol_o, e_rc);
    chk(t, "ap", cmd_ap_o, e_ap);
    chk(ts, "active", bank_active_o, {m_act[1] != 0, m_act[0] != 0});
    chk(ts, "rows", open_rows_o, {m_row[1][10:0], m_row[0][10:0]});
    chk(ts, "mode", mode_reg_o, m_mode);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 2; i++) begin m_act[i] = 0; m_row[i] = 0; m_rp[i] = 0; m_ap[i] = 0; end
    m_g = 0; m_mode = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R13", "reset cmd", cmd_o, 0);
    chk("R13", "reset viol", {viol_o, viol_code_o}, 0);
    chk("R13", "reset active", bank_active_o, 0);
    chk("R13", "reset mode", mode_reg_o, 0);
    @(negedge clk) rst_n = 1'b1;

    // directed corner cases
    step(2, 12'h233);            // R10 load mode
    step(3, 12'h005);            // R7 activate inside tMCD window
    step(1, 12'h000);            // R11 nop
    step(3, 12'h005);            // R2 open bank0
    step(3, 12'h00A);            // R9 bank0 already open
    step(5, 12'h800);            // R8 bank1 idle
    step(2, 12'h111);            // R6 load with open bank
    step(7, 12'h000);            // R6 refresh with open bank
    step(5, 12'h403);            // R4 read with auto-precharge
    for (int i = 0; i < BL + TRP; i++) step(3, 12'h007); // R4/R7 window edge
    step(3, 12'hC21);            // R2 open bank1
    step(6, 12'h815);            // R3 write, bank stays
    step(4, 12'h400);            // R5 close both
    step(0, 12'hFFF);            // R11 deselect in window
    step(3, 12'h801);            // R7 bank1 in tRP
    step(1, 12'h000);
    step(3, 12'h802);            // R2 bank1 reopens
    step(4, 12'h000);            // R5 close only bank0 (idle)
    step(4, 12'h800);            // R5 close bank1
    step(1, 12'h000); step(1, 12'h000);
    step(7, 12'h000);            // R6 refresh accepted
    step(7, 12'h000, 1'b0);      // R1 cke low -> other, R11
    for (int i = 0; i < TRC; i++) step(3, 12'h055);
    // R13: before the edge the output still shows the previous command
    @(negedge clk); drive(5, 12'h000, 1'b1);
    #2 chk("R13", "pre-edge cmd", cmd_o, e_cmd);
    model_step(12'h000);
    @(posedge clk); #2;
    chk("R13", "post-edge cmd", cmd_o, e_cmd);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int r, c;
      r = $urandom % 100;
      c = (r < 8) ? 0 : (r < 20) ? 1 : (r < 23) ? 2 : (r < 45) ? 3 :
          (r < 58) ? 4 : (r < 72) ? 5 : (r < 86) ? 6 : (r < 92) ? 7 : 8;
      step(c, 12'($urandom), ($urandom % 10) != 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule